// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is one counting slice of a performance-monitoring unit. Every clock it receives several event lanes. Each lane carries an 8-bit count of how many times its event occurred in that cycle. The block also receives one packet seen on a link, split into its fields. A control register chooses which source to count:

- an ordinary event lane, or
- a special code that counts packets passing a match/mask filter.

A subevent mask is ANDed into the chosen increment. The result is then either accumulated directly or turned into a condition by comparison with a threshold. That condition can be counted once per cycle it holds, or only on its rising edges.

Software reaches the slice through a single-cycle write port and a combinational read port. Four registers are visible: control, count, packet match and packet mask. The count is 48 bits wide and wraps silently. It can be loaded, cleared through a write-only control bit, and read at any time without disturbing collection.

Top module: `pmc_counter_slice`

## Requirements
- R1: After reset, all four registers read as zero, and the counter does not change until it is enabled.
- R2: Reading register 1 returns the 48-bit count in bits 47:0, with bits 63:48 read as zero. Reading the count does not disturb counting.
- R3: The count wraps modulo 2^48 and keeps counting after the carry out of bit 47.
- R4: The control register (address 0) holds these writable fields, which read back unchanged:
  - event code in bits 7:0
  - subevent mask in bits 15:8
  - edge mode in bit 18
  - count enable in bit 22
  - threshold in bits 31:24

  All other bits read 0, including reserved bit 16 and bit 17.
- R5: A control write with bit 17 set clears the count to zero, and the clear wins over any increment in that cycle. A write to address 1 loads the count from bits 47:0.
- R6: An event code i below the number of lanes selects lane i (bits 8i+7:8i of the event input). The lane value is ANDed with the subevent mask. Any code that is neither a lane number nor 0x38 contributes nothing.
- R7: With a threshold of 0 and edge mode off, the count grows by the masked increment every cycle.
- R8: With a non-zero threshold and edge mode off, the count grows by 1 in every cycle where the masked increment is greater than or equal to the threshold.
- R9: With edge mode on, the count grows by 1 only when the thresholded condition goes from 0 to 1. With a threshold of 0, the condition is "masked increment non-zero". The previous-condition register resets to 0.
- R10: Event code 0x38 selects the packet filter hit as an increment of 1, which is then subject to the subevent mask.
- R11: A packet hits when it is valid and every bit set in the mask register (address 3) equals the same bit of the match register (address 2). Both registers use this layout:
  - address in bits 47:0
  - node ID in bits 53:48
  - response in bits 55:54
  - message class in bits 59:56
  - opcode in bits 63:60
- R12: An input present before clock edge k shows in the count read after edge k+1. While count enable is 0, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for write and read |
| wdata | input | 64 | Write data |
| rd_data | output | 64 | Combinational read data of the addressed register |
| ev_inc | input | NUM_EV*8 | Per-cycle increments of the event lanes |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_opcode | input | 4 | Packet opcode |
| pkt_class | input | 4 | Packet message class |
| pkt_resp | input | 2 | Packet response field |
| pkt_nid | input | 6 | Packet node ID |
| pkt_addr | input | 48 | Packet physical address |

## Verification
The selected increment is registered at the first clock edge. The count changes at the second edge. A register write takes effect at the edge on which it is presented.

The bench therefore keeps every event input at zero while it reprograms the slice. It drives a pattern, then returns the inputs to zero and waits two full cycles before reading the count half a cycle after an edge. A dedicated check reads the count one edge after a single event, when the count must still be zero, and again one edge later, when it must hold the increment. The clear-priority check samples the count on the cycle right after a clear write that coincides with a live increment.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int BUS_W   = 64;
    localparam int LANE_W  = 8;
    localparam int RADDR_W = 2;

    localparam int OPC_W   = 4;
    localparam int CLS_W   = 4;
    localparam int RESP_W  = 2;
    localparam int NID_W   = 6;
    localparam int PADDR_W = 48;
    localparam int PKT_W   = OPC_W + CLS_W + RESP_W + NID_W + PADDR_W;

    localparam int SEL_LSB   = 0;
    localparam int UMASK_LSB = 8;
    localparam int CLR_BIT   = 17;
    localparam int EDGE_BIT  = 18;
    localparam int EN_BIT    = 22;
    localparam int THR_LSB   = 24;

    localparam logic [7:0] PKT_CODE = 8'h38;

    typedef enum logic [RADDR_W-1:0] {
        REG_CTL   = 2'd0,
        REG_CNT   = 2'd1,
        REG_MATCH = 2'd2,
        REG_MASK  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [LANE_W-1:0] sel;
        logic [LANE_W-1:0] umask;
        logic              edge_mode;
        logic              count_en;
        logic [LANE_W-1:0] thresh;
    } ctl_t;

    function automatic logic [BUS_W-1:0] ctl_to_word(input ctl_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[SEL_LSB   +: LANE_W] = c.sel;
        w[UMASK_LSB +: LANE_W] = c.umask;
        w[EDGE_BIT]            = c.edge_mode;
        w[EN_BIT]              = c.count_en;
        w[THR_LSB   +: LANE_W] = c.thresh;
        return w;
    endfunction

    function automatic ctl_t word_to_ctl(input logic [BUS_W-1:0] w);
        ctl_t c;
        c.sel       = w[SEL_LSB   +: LANE_W];
        c.umask     = w[UMASK_LSB +: LANE_W];
        c.edge_mode = w[EDGE_BIT];
        c.count_en  = w[EN_BIT];
        c.thresh    = w[THR_LSB   +: LANE_W];
        return c;
    endfunction

endpackage

// File: rtl/pmc_pkt_filter.sv
module pmc_pkt_filter
    import pmc_pkg::*;
(
    input  logic               valid,
    input  logic [OPC_W-1:0]   opcode,
    input  logic [CLS_W-1:0]   msg_class,
    input  logic [RESP_W-1:0]  resp,
    input  logic [NID_W-1:0]   nid,
    input  logic [PADDR_W-1:0] paddr,
    input  logic [PKT_W-1:0]   match_val,
    input  logic [PKT_W-1:0]   mask_val,
    output logic               hit
);
    logic [PKT_W-1:0] pkt_word;
    logic [PKT_W-1:0] diff;

    always_comb begin
        pkt_word = {opcode, msg_class, resp, nid, paddr};
        diff     = (pkt_word ^ match_val) & mask_val;
        hit      = valid && (diff == '0);
    end
endmodule

// File: rtl/pmc_event_mux.sv
module pmc_event_mux
    import pmc_pkg::*;
#(
    parameter int NUM_EV = 4
) (
    input  logic [NUM_EV*LANE_W-1:0] ev_inc,
    input  logic                     pkt_hit,
    input  logic [LANE_W-1:0]        sel,
    input  logic [LANE_W-1:0]        umask,
    output logic [LANE_W-1:0]        inc
);
    logic [NUM_EV-1:0][LANE_W-1:0] lane;
    logic [LANE_W-1:0]             raw;

    for (genvar g = 0; g < NUM_EV; g++) begin : g_lane
        assign lane[g] = ev_inc[g*LANE_W +: LANE_W];
    end

    always_comb begin
        raw = '0;
        if (sel == PKT_CODE) begin
            raw = {{(LANE_W-1){1'b0}}, pkt_hit};
        end else begin
            for (int i = 0; i < NUM_EV; i++) begin
                if (sel == LANE_W'(i)) raw = lane[i];
            end
        end
        inc = raw & umask;
    end
endmodule

// File: rtl/pmc_thresh_edge.sv
module pmc_thresh_edge
    import pmc_pkg::*;
(
    input  logic [LANE_W-1:0] inc,
    input  logic [LANE_W-1:0] thresh,
    input  logic              edge_mode,
    input  logic              prev_cond,
    output logic              cond,
    output logic [LANE_W-1:0] add
);
    logic thr_zero;

    always_comb begin
        thr_zero = (thresh == '0);
        cond     = thr_zero ? (inc != '0) : (inc >= thresh);
        if (edge_mode)
            add = {{(LANE_W-1){1'b0}}, cond & ~prev_cond};
        else if (thr_zero)
            add = inc;
        else
            add = {{(LANE_W-1){1'b0}}, cond};
    end
endmodule

// File: rtl/pmc_counter_slice.sv
module pmc_counter_slice
    import pmc_pkg::*;
#(
    parameter int NUM_EV = 4,
    parameter int CNT_W  = 48
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [RADDR_W-1:0]       addr,
    input  logic [BUS_W-1:0]         wdata,
    output logic [BUS_W-1:0]         rd_data,
    input  logic [NUM_EV*LANE_W-1:0] ev_inc,
    input  logic                     pkt_valid,
    input  logic [OPC_W-1:0]         pkt_opcode,
    input  logic [CLS_W-1:0]         pkt_class,
    input  logic [RESP_W-1:0]        pkt_resp,
    input  logic [NID_W-1:0]         pkt_nid,
    input  logic [PADDR_W-1:0]       pkt_addr
);
    typedef struct packed {
        ctl_t              ctl;
        logic [LANE_W-1:0] inc;
        logic              prev;
        logic [CNT_W-1:0]  cnt;
        logic [PKT_W-1:0]  match_val;
        logic [PKT_W-1:0]  mask_val;
    } state_t;

    state_t s_d, s_q;

    logic              pkt_hit;
    logic [LANE_W-1:0] inc_sel;
    logic              cond;
    logic [LANE_W-1:0] add;
    logic [CNT_W-1:0]  cnt_now;
    logic              en_now;
    logic              edge_now;

    pmc_pkt_filter u_filter (
        .valid     (pkt_valid),
        .opcode    (pkt_opcode),
        .msg_class (pkt_class),
        .resp      (pkt_resp),
        .nid       (pkt_nid),
        .paddr     (pkt_addr),
        .match_val (s_q.match_val),
        .mask_val  (s_q.mask_val),
        .hit       (pkt_hit)
    );

    pmc_event_mux #(.NUM_EV(NUM_EV)) u_mux (
        .ev_inc  (ev_inc),
        .pkt_hit (pkt_hit),
        .sel     (s_q.ctl.sel),
        .umask   (s_q.ctl.umask),
        .inc     (inc_sel)
    );

    pmc_thresh_edge u_thr (
        .inc       (s_q.inc),
        .thresh    (s_q.ctl.thresh),
        .edge_mode (s_q.ctl.edge_mode),
        .prev_cond (s_q.prev),
        .cond      (cond),
        .add       (add)
    );

    always_comb begin
        s_d      = s_q;
        s_d.inc  = inc_sel;
        s_d.prev = cond;
        if (s_q.ctl.count_en)
            s_d.cnt = s_q.cnt + CNT_W'(add);
        if (wr_en) begin
            unique case (reg_sel_e'(addr))
                REG_CTL: begin
                    s_d.ctl = word_to_ctl(wdata);
                    if (wdata[CLR_BIT]) s_d.cnt = '0;
                end
                REG_CNT:   s_d.cnt       = wdata[CNT_W-1:0];
                REG_MATCH: s_d.match_val = wdata[PKT_W-1:0];
                REG_MASK:  s_d.mask_val  = wdata[PKT_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (reg_sel_e'(addr))
            REG_CTL:   rd_data = ctl_to_word(s_q.ctl);
            REG_CNT:   rd_data = BUS_W'(s_q.cnt);
            REG_MATCH: rd_data = BUS_W'(s_q.match_val);
            REG_MASK:  rd_data = BUS_W'(s_q.mask_val);
            default:   rd_data = '0;
        endcase
    end

    assign cnt_now  = s_q.cnt;
    assign en_now   = s_q.ctl.count_en;
    assign edge_now = s_q.ctl.edge_mode;

endmodule

// File: rtl/pmc_counter_slice_chk.sv
module pmc_counter_slice_chk
    import pmc_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [RADDR_W-1:0] addr,
    input logic [BUS_W-1:0]   wdata,
    input logic [BUS_W-1:0]   rd_data,
    input logic [CNT_W-1:0]   cnt_now,
    input logic               en_now,
    input logic               edge_now
);
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == REG_CNT) |-> (rd_data[BUS_W-1:CNT_W] == '0));

    assert_ctl_rsv_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == REG_CTL) |-> (rd_data[CLR_BIT:CLR_BIT-1] == 2'b00));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_CTL && wdata[CLR_BIT]) |=> (cnt_now == '0));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_now && !wr_en) |=> $stable(cnt_now));

    assert_edge_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_now && edge_now && !wr_en) |=> (CNT_W'(cnt_now - $past(cnt_now)) <= CNT_W'(1)));
endmodule

bind pmc_counter_slice pmc_counter_slice_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rd_data  (rd_data),
    .cnt_now  (cnt_now),
    .en_now   (en_now),
    .edge_now (edge_now)
);

// File: tb/pmc_counter_slice_test.sv
module pmc_counter_slice_test;
    localparam int NEV = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [63:0]  wdata = '0;
    logic [63:0]  rd_data;
    logic [NEV*8-1:0] ev_inc = '0;
    logic         pkt_valid = 1'b0;
    logic [3:0]   pkt_opcode = '0;
    logic [3:0]   pkt_class = '0;
    logic [1:0]   pkt_resp = '0;
    logic [5:0]   pkt_nid = '0;
    logic [47:0]  pkt_addr = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pmc_counter_slice #(.NUM_EV(NEV), .CNT_W(48)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .ev_inc(ev_inc), .pkt_valid(pkt_valid),
        .pkt_opcode(pkt_opcode), .pkt_class(pkt_class), .pkt_resp(pkt_resp),
        .pkt_nid(pkt_nid), .pkt_addr(pkt_addr)
    );

    function automatic logic [63:0] mk_ctl(input logic [7:0] sel, input logic [7:0] um,
                                           input logic edg, input logic en,
                                           input logic [7:0] th, input logic clr);
        logic [63:0] w;
        w = '0;
        w[7:0] = sel; w[15:8] = um; w[17] = clr; w[18] = edg; w[22] = en; w[31:24] = th;
        return w;
    endfunction

    function automatic logic [7:0] pat(input int c, input int s);
        if (c % 5 == 3) return 8'd0;
        return 8'((c * 53 + s * 29 + 7) % 256);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic check(input logic [1:0] a, input logic [63:0] exp, input string req);
        addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s: reg %0d actual %h expected %h", req, a, rd_data, exp);
        end
    endtask

    task automatic set_lanes(input int sel, input logic [7:0] v);
        for (int j = 0; j < NEV; j++)
            ev_inc[j*8 +: 8] = (j == sel) ? v : (v ^ 8'h5a ^ 8'(j));
    endtask

    task automatic settle();
        ev_inc = '0; pkt_valid = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] exp;
        logic [47:0] e48;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(2'd0, 64'd0, "R1 ctl");
        check(2'd1, 64'd0, "R1 cnt");
        check(2'd2, 64'd0, "R1 match");
        check(2'd3, 64'd0, "R1 mask");
        set_lanes(0, 8'd9);
        @(negedge clk); @(negedge clk);
        settle();
        check(2'd1, 64'd0, "R1 disabled after reset");

        // R4 control readback, reserved and clear bits read zero
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        check(2'd0, 64'h0000_0000_FF44_FFFF, "R4 ctl readback");

        // R7 / R6 sweep: every lane, several masks, threshold 0
        for (int l = 0; l < NEV; l++) begin
            for (int m = 0; m < 3; m++) begin
                logic [7:0] um;
                um = (m == 0) ? 8'hff : ((m == 1) ? 8'h0f : 8'ha5);
                wr(2'd0, mk_ctl(8'(l), um, 1'b0, 1'b1, 8'd0, 1'b1));
                e48 = '0;
                for (int c = 0; c < 16; c++) begin
                    set_lanes(l, pat(c, l + m));
                    e48 += 48'(pat(c, l + m) & um);
                    @(negedge clk);
                end
                settle();
                check(2'd1, 64'(e48), "R7 R6 lane sum");
            end
        end

        // R6 unused code contributes nothing
        wr(2'd0, mk_ctl(8'd20, 8'hff, 1'b0, 1'b1, 8'd0, 1'b1));
        for (int c = 0; c < 8; c++) begin set_lanes(c % NEV, 8'hff); @(negedge clk); end
        settle();
        check(2'd1, 64'd0, "R6 unused code");

        // R8 threshold sweep
        for (int t = 1; t < 256; t += 37) begin
            wr(2'd0, mk_ctl(8'd2, 8'hff, 1'b0, 1'b1, 8'(t), 1'b1));
            e48 = '0;
            for (int c = 0; c < 20; c++) begin
                set_lanes(2, pat(c, t));
                if (int'(pat(c, t)) >= t) e48++;
                @(negedge clk);
            end
            settle();
            check(2'd1, 64'(e48), "R8 threshold count");
        end

        // R9 edge mode sweep over thresholds, including 0
        for (int t = 0; t < 256; t += 51) begin
            logic prev;
            wr(2'd0, mk_ctl(8'd1, 8'hff, 1'b1, 1'b1, 8'(t), 1'b1));
            e48 = '0; prev = 1'b0;
            for (int c = 0; c < 20; c++) begin
                logic cnd;
                set_lanes(1, pat(c, t + 3));
                cnd = (t == 0) ? (pat(c, t + 3) != 0) : (int'(pat(c, t + 3)) >= t);
                if (cnd && !prev) e48++;
                prev = cnd;
                @(negedge clk);
            end
            settle();
            check(2'd1, 64'(e48), "R9 edge count");
        end

        // R12 latency and R2 read while counting
        wr(2'd0, mk_ctl(8'd0, 8'hff, 1'b0, 1'b1, 8'd0, 1'b1));
        set_lanes(0, 8'd17);
        @(negedge clk);
        ev_inc = '0;
        check(2'd1, 64'd0, "R12 not yet after one edge");
        @(negedge clk);
        check(2'd1, 64'd17, "R12 due after second edge");
        for (int c = 0; c < 6; c++) begin
            set_lanes(0, 8'd3);
            check(2'd1, 64'd17 + 64'(c > 1 ? 3 * (c - 1) : 0), "R2 read during count");
            @(negedge clk);
        end
        settle();
        check(2'd1, 64'd35, "R2 reads did not disturb");

        // R12 enable off holds
        wr(2'd0, mk_ctl(8'd0, 8'hff, 1'b0, 1'b0, 8'd0, 1'b0));
        for (int c = 0; c < 6; c++) begin set_lanes(0, 8'd40); @(negedge clk); end
        settle();
        check(2'd1, 64'd35, "R12 hold when disabled");

        // R5 clear wins over concurrent increment
        wr(2'd0, mk_ctl(8'd0, 8'hff, 1'b0, 1'b1, 8'd0, 1'b0));
        set_lanes(0, 8'd6);
        @(negedge clk); @(negedge clk);
        wr_en = 1'b1; addr = 2'd0; wdata = mk_ctl(8'd0, 8'hff, 1'b0, 1'b1, 8'd0, 1'b1);
        @(negedge clk);
        wr_en = 1'b0; ev_inc = '0;
        check(2'd1, 64'd0, "R5 clear priority");
        settle();
        check(2'd1, 64'd6, "R5 pipelined increment after clear");

        // R5 load and R3 wrap
        wr(2'd1, 64'hFFFF_0000_0000_0000 | 64'h0000_FFFF_FFFF_FFFD);
        check(2'd1, 64'h0000_FFFF_FFFF_FFFD, "R5 load R2 upper zero");
        set_lanes(0, 8'd5);
        @(negedge clk);
        settle();
        check(2'd1, 64'd2, "R3 wrap");

        // R10 / R11 packet filter
        exp = {4'ha, 4'h3, 2'b01, 6'h15, 48'h0000_1234_5678};
        wr(2'd2, exp);
        wr(2'd3, 64'hFF00_0000_0000_0000);
        check(2'd2, exp, "R11 match readback");
        wr(2'd0, mk_ctl(8'h38, 8'h01, 1'b0, 1'b1, 8'd0, 1'b1));
        e48 = '0;
        for (int c = 0; c < 64; c++) begin
            pkt_valid  = (c % 7) != 5;
            pkt_opcode = 4'(c % 16 == 0 ? 10 : c % 11);
            pkt_class  = 4'(c % 3 == 0 ? 3 : c % 5);
            pkt_resp   = 2'(c);
            pkt_nid    = 6'(c * 5);
            pkt_addr   = 48'(c * 977);
            if (pkt_valid && pkt_opcode == 4'ha && pkt_class == 4'h3) e48++;
            @(negedge clk);
        end
        settle();
        check(2'd1, 64'(e48), "R10 R11 masked packet hits");

        wr(2'd3, 64'd0);
        wr(2'd0, mk_ctl(8'h38, 8'h01, 1'b0, 1'b1, 8'd0, 1'b1));
        for (int c = 0; c < 10; c++) begin pkt_valid = (c < 7); @(negedge clk); end
        settle();
        check(2'd1, 64'd7, "R11 empty mask valid only");

        wr(2'd0, mk_ctl(8'h38, 8'h00, 1'b0, 1'b1, 8'd0, 1'b1));
        for (int c = 0; c < 10; c++) begin pkt_valid = 1'b1; @(negedge clk); end
        settle();
        check(2'd1, 64'd0, "R10 subevent mask blocks hit");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule